// File: doc/BRIEF.md
# Flash Write-Status Reporter

This block forms the word a NOR flash returns when the host reads it while an embedded program or erase is running. The command engine supplies the busy and suspend flags, the most significant bit of the word being programmed and the sector whose erase is suspended. The host supplies a read strobe and the sector field of its read address. Each new read produces one of two results. The first is a status word made of a polling bit, an in-progress toggle bit and a suspended-sector toggle bit. The second is the true array word, passed through unchanged.

The block also drives the ready/busy line as an open-drain pull-down. The pull-down is active while either embedded algorithm runs. A read is counted once, on the cycle the strobe is first sampled high. Holding the strobe high does not count as more reads. Both toggle bits start at 0 after reset.

Top module: `flash_wstat_top`

## Requirements
- R1: After reset, `rd_data_o` is 0, `rd_status_o` is 0 and `rb_pull_low_o` is 0.
- R2: When a read happens while a program is busy, the result is a status word. Its bit 7 is the inverse of `prog_msb_i`.
- R3: Each read while a program or erase is busy inverts the in-progress toggle. The toggle appears at bit 6. The first such read after reset returns 1.
- R4: Reads made while neither algorithm is busy leave the in-progress toggle unchanged.
- R5: The suspended-sector toggle appears at bit 2. It inverts only on a read made while erase is suspended and `rd_sector_i` equals `susp_sector_i`. While erase is suspended and no program is busy, such a read returns a status word with bit 7 = 1.
- R6: A read while an erase is busy, and no program is busy, returns a status word with bit 7 = 0.
- R7: A read while nothing is busy, and that does not hit the suspended sector, returns `array_data_i` with `rd_status_o` = 0.
- R8: `rb_pull_low_o` goes to 1 one cycle after either busy input rises. It returns to 0 one cycle after both busy inputs are low.
- R9: The read outputs change only in the cycle after a rising edge of `rd_strobe_i`. A strobe held high for several cycles counts as one read.
- R10: In a status word, every bit other than 7, 6 and 2 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_busy_i | input | 1 | Embedded program running |
| erase_busy_i | input | 1 | Embedded erase running |
| erase_susp_i | input | 1 | Erase currently suspended |
| prog_msb_i | input | 1 | Bit 7 of the word being programmed |
| susp_sector_i | input | SECT_W | Sector whose erase is suspended |
| rd_strobe_i | input | 1 | Read strobe, active high |
| rd_sector_i | input | SECT_W | Sector field of the read address |
| array_data_i | input | DATA_W | True array word at the read address |
| rd_data_o | output | DATA_W | Word returned for the latest read |
| rd_status_o | output | 1 | Latest read returned status, not array data |
| rb_pull_low_o | output | 1 | Pull the ready/busy line low |

## Verification
The bench targets the toggle history across mixed read types. A design that advanced the in-progress toggle on idle or suspended-sector reads would show a bit 6 value out of step on the next busy read. A strobe held high for three cycles catches a design that counts a read on every high cycle; such a design would flip bit 6 three times. Reads of a different sector during suspend catch a bit 2 that flips on every suspended-period read or fails to fall back to array data. A program inside an erase suspend catches a wrong priority: polling bit 7 would report the erase state instead of the inverted program bit.

// File: rtl/flash_wstat_pkg.sv
package flash_wstat_pkg;
    localparam int POLL_POS = 7;
    localparam int TGL_POS  = 6;
    localparam int SUSP_POS = 2;

    typedef enum logic [1:0] {
        RK_ARRAY = 2'd0,
        RK_PROG  = 2'd1,
        RK_ERASE = 2'd2,
        RK_SUSP  = 2'd3
    } rd_kind_e;
endpackage

// File: rtl/flash_wstat_edge.sv
module flash_wstat_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic rd_evt_o
);
    logic prev_q, prev_d;

    always_comb begin
        prev_d   = strobe_i;
        rd_evt_o = strobe_i && !prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    AST_ONE_EVENT_PER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_evt_o |=> !rd_evt_o); // R9
endmodule

// File: rtl/flash_wstat_toggles.sv
module flash_wstat_toggles (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_evt_i,
    input  logic alg_busy_i,
    input  logic susp_hit_i,
    output logic tgl_nxt_o,
    output logic susp_tgl_nxt_o
);
    typedef struct packed {
        logic tgl;
        logic susp_tgl;
    } tgl_t;

    tgl_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (rd_evt_i && alg_busy_i) st_d.tgl      = !st_q.tgl;
        if (rd_evt_i && susp_hit_i) st_d.susp_tgl = !st_q.susp_tgl;
        tgl_nxt_o      = st_d.tgl;
        susp_tgl_nxt_o = st_d.susp_tgl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TGL_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_evt_i && alg_busy_i) |=> $stable(st_q.tgl)); // R4
    AST_SUSP_TGL_ONLY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_evt_i && susp_hit_i) |=> $stable(st_q.susp_tgl)); // R5
    AST_TGL_FLIPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt_i && alg_busy_i) |=> st_q.tgl != $past(st_q.tgl)); // R3
endmodule

// File: rtl/flash_wstat_mux.sv
module flash_wstat_mux
    import flash_wstat_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  rd_kind_e          kind_i,
    input  logic              prog_msb_i,
    input  logic              tgl_i,
    input  logic              susp_tgl_i,
    input  logic [DATA_W-1:0] array_i,
    output logic [DATA_W-1:0] word_o,
    output logic              is_status_o
);
    always_comb begin
        word_o      = '0;
        is_status_o = (kind_i != RK_ARRAY);
        if (kind_i == RK_ARRAY) begin
            word_o = array_i;
        end else begin
            word_o[TGL_POS]  = tgl_i;
            word_o[SUSP_POS] = susp_tgl_i;
            case (kind_i)
                RK_PROG:  word_o[POLL_POS] = !prog_msb_i;
                RK_ERASE: word_o[POLL_POS] = 1'b0;
                default:  word_o[POLL_POS] = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/flash_wstat_top.sv
module flash_wstat_top
    import flash_wstat_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SECT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_busy_i,
    input  logic              erase_busy_i,
    input  logic              erase_susp_i,
    input  logic              prog_msb_i,
    input  logic [SECT_W-1:0] susp_sector_i,
    input  logic              rd_strobe_i,
    input  logic [SECT_W-1:0] rd_sector_i,
    input  logic [DATA_W-1:0] array_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_status_o,
    output logic              rb_pull_low_o
);
    localparam int STATUS_MASK = (1 << POLL_POS) | (1 << TGL_POS) | (1 << SUSP_POS);

    typedef struct packed {
        logic [DATA_W-1:0] dq;
        logic              st;
        logic              rb;
    } out_t;

    out_t              cur_q, nxt_d;
    logic              rd_evt, alg_busy, susp_hit, tgl_nxt, susp_tgl_nxt, word_st;
    logic [DATA_W-1:0] word;
    rd_kind_e          kind;

    flash_wstat_edge u_edge (
        .clk(clk), .rst_n(rst_n), .strobe_i(rd_strobe_i), .rd_evt_o(rd_evt)
    );

    always_comb begin
        alg_busy = prog_busy_i || erase_busy_i;
        susp_hit = erase_susp_i && (rd_sector_i == susp_sector_i);
        if (prog_busy_i)       kind = RK_PROG;
        else if (erase_busy_i) kind = RK_ERASE;
        else if (susp_hit)     kind = RK_SUSP;
        else                   kind = RK_ARRAY;
    end

    flash_wstat_toggles u_tgl (
        .clk(clk), .rst_n(rst_n), .rd_evt_i(rd_evt), .alg_busy_i(alg_busy),
        .susp_hit_i(susp_hit), .tgl_nxt_o(tgl_nxt), .susp_tgl_nxt_o(susp_tgl_nxt)
    );

    flash_wstat_mux #(.DATA_W(DATA_W)) u_mux (
        .kind_i(kind), .prog_msb_i(prog_msb_i), .tgl_i(tgl_nxt),
        .susp_tgl_i(susp_tgl_nxt), .array_i(array_data_i),
        .word_o(word), .is_status_o(word_st)
    );

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.rb = alg_busy;
        if (rd_evt) begin
            nxt_d.dq = word;
            nxt_d.st = word_st;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rd_data_o     = cur_q.dq;
    assign rd_status_o   = cur_q.st;
    assign rb_pull_low_o = cur_q.rb;

    AST_RB_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_busy_i || erase_busy_i) |=> rb_pull_low_o); // R8
    AST_RB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_busy_i || erase_busy_i) |=> !rb_pull_low_o); // R8
    AST_PROG_POLL_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && prog_busy_i) |=> rd_status_o && (rd_data_o[POLL_POS] == !$past(prog_msb_i))); // R2
    AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && !alg_busy && !susp_hit) |=> !rd_status_o && (rd_data_o == $past(array_data_i))); // R7
    AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_evt |=> $stable(rd_data_o) && $stable(rd_status_o)); // R9
    AST_STATUS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status_o |-> ((rd_data_o & ~DATA_W'(STATUS_MASK)) == '0)); // R10
endmodule

// File: tb/tb_flash_wstat_top.sv
module tb_flash_wstat_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pb = 0, eb = 0, es = 0, msb = 0, strobe = 0;
    logic [3:0] ssec = 0, rsec = 0;
    logic [7:0] arr = 0;
    logic [7:0] dq;
    logic       st, rb;

    int checks = 0, fails = 0;
    bit done = 0;

    // behavioural reference state
    int    m_t6 = 0, m_t2 = 0, m_dq = 0, m_st = 0, m_rb = 0, m_prev = 0;
    string m_tag = "R1";

    always #2.5 clk = ~clk;

    flash_wstat_top dut (
        .clk(clk), .rst_n(rst_n), .prog_busy_i(pb), .erase_busy_i(eb),
        .erase_susp_i(es), .prog_msb_i(msb), .susp_sector_i(ssec),
        .rd_strobe_i(strobe), .rd_sector_i(rsec), .array_data_i(arr),
        .rd_data_o(dq), .rd_status_o(st), .rb_pull_low_o(rb)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_t6 = 0; m_t2 = 0; m_dq = 0; m_st = 0; m_rb = 0; m_prev = 0; m_tag = "R1";
        end else begin
            m_rb = (pb || eb) ? 1 : 0;
            if (strobe && m_prev == 0) begin
                if (pb || eb) m_t6 = 1 - m_t6;
                if (es && rsec == ssec) m_t2 = 1 - m_t2;
                m_st = 1;
                if (pb) begin
                    m_dq = (msb ? 0 : 128) + m_t6 * 64 + m_t2 * 4; m_tag = "R2";
                end else if (eb) begin
                    m_dq = m_t6 * 64 + m_t2 * 4; m_tag = "R6";
                end else if (es && rsec == ssec) begin
                    m_dq = 128 + m_t6 * 64 + m_t2 * 4; m_tag = "R5";
                end else begin
                    m_dq = arr; m_st = 0; m_tag = "R7";
                end
            end else begin
                m_tag = "R9";
            end
            m_prev = strobe ? 1 : 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(m_tag, {st, dq}, m_st * 256 + m_dq);
            chk("R8", rb, m_rb);
        end
    end

    task automatic rd(input logic [3:0] sec, input logic [7:0] data, input int hold);
        rsec = sec; arr = data; strobe = 1;
        repeat (hold) @(negedge clk);
        strobe = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", {rb, st, dq}, 0);
        rst_n = 1;
        @(negedge clk);
        rd(4'd3, 8'h5A, 1);
        chk("R7", dq, 8'h5A);
        pb = 1; msb = 1;
        @(negedge clk);
        chk("R8", rb, 1);
        rd(4'd3, 8'hFF, 1);
        chk("R3", dq[6], 1);
        chk("R2", dq[7], 0);
        chk("R10", dq & 8'h3B, 0);
        rd(4'd3, 8'hFF, 1);
        chk("R3", dq[6], 0);
        rd(4'd3, 8'hFF, 3);          // held strobe counts once
        chk("R9", dq[6], 1);
        msb = 0;
        rd(4'd1, 8'h00, 1);
        chk("R2", dq[7], 1);
        pb = 0;
        @(negedge clk);
        chk("R8", rb, 0);
        rd(4'd1, 8'hC3, 1);
        chk("R7", {st, dq}, 9'h0C3);
        eb = 1; ssec = 4'd5;
        @(negedge clk);
        rd(4'd7, 8'hFF, 1);
        chk("R6", dq[7], 0);
        chk("R4", dq[6], 1);         // idle read did not advance toggle
        eb = 0; es = 1;
        @(negedge clk);
        rd(4'd5, 8'h11, 1);
        chk("R5", {st, dq}, 9'h1C4);
        rd(4'd5, 8'h11, 1);
        chk("R5", dq[2], 0);
        chk("R4", dq[6], 1);
        rd(4'd2, 8'h3C, 1);
        chk("R7", {st, dq}, 9'h03C);
        rd(4'd5, 8'h11, 1);
        chk("R5", dq[2], 1);
        pb = 1; msb = 1;
        rd(4'd2, 8'h00, 1);
        chk("R2", dq, 8'h04);
        rd(4'd5, 8'h00, 1);
        chk("R5", dq, 8'h40);
        pb = 0; es = 0;
        @(negedge clk);
        rd(4'd5, 8'hA5, 1);
        chk("R7", {st, dq}, 9'h0A5);
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule